// File: doc/BRIEF.md
# UART FIFO Control Register Unit

This unit is the write-only FIFO control register of one UART channel with 16-entry transmit and receive FIFOs. The host writes one byte. The unit turns that byte into a FIFO enable, a DMA-mode flag, a 2-bit receive trigger select and two single-clock clear pulses, one for each FIFO. A byte whose bit 0 is clear turns the FIFOs off and has no other effect.

The unit also keeps the occupancy count of each FIFO from push and pop strobes. It compares the receive count against the selected trigger level and raises a receive interrupt request. The clear pulses reset only these counts (the FIFO pointers). The serial shift registers are not part of this unit and are never touched.

Top module: `fcr_unit`

## Requirements
- R1: After reset, all of these are 0: `fifo_en`, `dma_mode`, `rx_trig_sel`, both clear pulses, both levels and `rx_irq`.
- R2: Bit 0 of every accepted write is loaded into `fifo_en`. When bit 0 of a write is 0, bits 7:1 of that write are ignored: `dma_mode` and `rx_trig_sel` keep their values and no clear pulse is produced.
- R3: A write with bits 1 and 0 both set drives `rx_fifo_clr` high for exactly the one clock after the write. `rx_level` is 0 after that clock, and `tx_level` is unchanged.
- R4: A write with bits 2 and 0 both set drives `tx_fifo_clr` high for exactly the one clock after the write. `tx_level` is 0 after that clock, and `rx_level` is unchanged.
- R5: Bit 3 of an enabled write sets `dma_mode` (1 = DMA, 0 = normal). Bits 5:4 have no effect on any output.
- R6: Bits 7:6 of an enabled write load `rx_trig_sel`. The codes 00, 01, 10 and 11 select trigger levels of 1, 4, 8 and 14 characters.
- R7: Each level counts pushes up and pops down. A clock with both a push and a pop leaves the level unchanged, except at empty, where the push alone counts. A push at 16 with no pop is ignored, and a pop at 0 is ignored.
- R8: `rx_irq` is high one clock after `rx_level` is at or above the selected trigger level while FIFOs are enabled. It goes low one clock after a pop takes the level below the trigger.
- R9: While `fifo_en` is 0, both levels are held at 0, pushes and pops are ignored, and `rx_irq` is low.
- R10: A push or pop in the clock where that FIFO's clear pulse is high is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write byte |
| rx_push | input | 1 | Character written into the receive FIFO |
| rx_pop | input | 1 | Character read from the receive FIFO |
| tx_push | input | 1 | Character written into the transmit FIFO |
| tx_pop | input | 1 | Character taken from the transmit FIFO |
| fifo_en | output | 1 | Both FIFOs enabled |
| dma_mode | output | 1 | DMA mode selected |
| rx_trig_sel | output | 2 | Receive trigger select code |
| rx_fifo_clr | output | 1 | One-clock receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | One-clock transmit FIFO clear pulse |
| rx_level | output | 5 | Receive FIFO occupancy |
| tx_level | output | 5 | Transmit FIFO occupancy |
| rx_irq | output | 1 | Receive trigger interrupt request |

## Verification
The bench targets these corner cases:
- **Write with bit 0 clear and other bits set.** A design that gates wrongly would change the DMA flag or trigger code, or would fire a clear pulse.
- **A clear aimed at one FIFO.** A design that crosses the channels would also wipe the other FIFO's level.
- **A push in the clear clock.** A design that lets it through would leave a level of 1 after the clear.
- **Saturation, and push with pop together at empty and at full.** A design that gets these wrong would wrap the count or lose a character.
- **Crossing each of the four trigger levels, then disabling the FIFOs.** A design with a wrong level table or missing enable gating would give an interrupt early, late, or while disabled.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  localparam int HOST_W = 8;
  localparam int NUM_Q  = 2;   // queue 0 = receive, queue 1 = transmit
  localparam int Q_RX   = 0;
  localparam int Q_TX   = 1;

  typedef struct packed {
    logic       en;
    logic       rx_clr;
    logic       tx_clr;
    logic       dma;
    logic [1:0] trig;
  } fcr_fields_t;

  function automatic fcr_fields_t split_byte(input logic [HOST_W-1:0] b);
    fcr_fields_t f;
    f.en     = b[0];
    f.rx_clr = b[1];
    f.tx_clr = b[2];
    f.dma    = b[3];
    f.trig   = b[7:6];
    return f;
  endfunction
endpackage

// File: rtl/fcr_decode.sv
module fcr_decode
  import fcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [HOST_W-1:0] wr_data,
  output logic              fifo_en,
  output logic              dma_mode,
  output logic [1:0]        trig_sel,
  output logic              rx_clr,
  output logic              tx_clr
);
  fcr_fields_t f;
  assign f = split_byte(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en  <= 1'b0;
      dma_mode <= 1'b0;
      trig_sel <= 2'b00;
      rx_clr   <= 1'b0;
      tx_clr   <= 1'b0;
    end else begin
      rx_clr <= 1'b0;
      tx_clr <= 1'b0;
      if (wr_en) begin
        fifo_en <= f.en;
        if (f.en) begin
          dma_mode <= f.dma;
          trig_sel <= f.trig;
          rx_clr   <= f.rx_clr;
          tx_clr   <= f.tx_clr;
        end
      end
    end
  end

  // R2
  gated_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[0]) |=> ($stable(dma_mode) && $stable(trig_sel) && !rx_clr && !tx_clr));
  // R3
  rx_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> !rx_clr);
  // R4
  tx_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> !tx_clr);
endmodule

// File: rtl/fifo_level_ctr.sv
module fifo_level_ctr #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  logic not_empty, pop_ok, push_ok;
  assign not_empty = (level != '0);
  assign pop_ok    = pop && not_empty;
  assign push_ok   = push && ((level < FULL) || pop_ok);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      level <= '0;
    end else begin
      unique case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= FULL);
  // R10
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0));
endmodule

// File: rtl/rx_trig_irq.sv
module rx_trig_irq #(
  parameter int LVL_W  = 5,
  parameter int TRIG_A = 1,
  parameter int TRIG_B = 4,
  parameter int TRIG_C = 8,
  parameter int TRIG_D = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic [LVL_W-1:0] level,
  output logic             irq
);
  logic [LVL_W-1:0] thresh;

  always_comb begin
    unique case (trig_sel)
      2'b00:   thresh = LVL_W'(TRIG_A);
      2'b01:   thresh = LVL_W'(TRIG_B);
      2'b10:   thresh = LVL_W'(TRIG_C);
      default: thresh = LVL_W'(TRIG_D);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= fifo_en && (level >= thresh);
  end

  // R9
  irq_off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_en) |-> !irq);
endmodule

// File: rtl/fcr_unit.sv
module fcr_unit
  import fcr_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TRIG_A = 1,
  parameter int TRIG_B = 4,
  parameter int TRIG_C = 8,
  parameter int TRIG_D = 14,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              tx_push,
  input  logic              tx_pop,
  output logic              fifo_en,
  output logic              dma_mode,
  output logic [1:0]        rx_trig_sel,
  output logic              rx_fifo_clr,
  output logic              tx_fifo_clr,
  output logic [LVL_W-1:0]  rx_level,
  output logic [LVL_W-1:0]  tx_level,
  output logic              rx_irq
);
  logic [NUM_Q-1:0]   q_clr, q_push, q_pop;
  logic [LVL_W-1:0]   q_level [NUM_Q];

  fcr_decode u_decode (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .fifo_en  (fifo_en),
    .dma_mode (dma_mode),
    .trig_sel (rx_trig_sel),
    .rx_clr   (rx_fifo_clr),
    .tx_clr   (tx_fifo_clr)
  );

  assign q_clr[Q_RX]  = rx_fifo_clr || !fifo_en;
  assign q_clr[Q_TX]  = tx_fifo_clr || !fifo_en;
  assign q_push[Q_RX] = rx_push;
  assign q_push[Q_TX] = tx_push;
  assign q_pop[Q_RX]  = rx_pop;
  assign q_pop[Q_TX]  = tx_pop;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    fifo_level_ctr #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_ctr (
      .clk   (clk),
      .rst   (rst),
      .clr   (q_clr[g]),
      .push  (q_push[g]),
      .pop   (q_pop[g]),
      .level (q_level[g])
    );
  end

  assign rx_level = q_level[Q_RX];
  assign tx_level = q_level[Q_TX];

  rx_trig_irq #(
    .LVL_W(LVL_W), .TRIG_A(TRIG_A), .TRIG_B(TRIG_B), .TRIG_C(TRIG_C), .TRIG_D(TRIG_D)
  ) u_irq (
    .clk      (clk),
    .rst      (rst),
    .fifo_en  (fifo_en),
    .trig_sel (rx_trig_sel),
    .level    (rx_level),
    .irq      (rx_irq)
  );

  // R3
  rx_clear_spares_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_fifo_clr && !tx_fifo_clr && fifo_en && !tx_push && !tx_pop) |=> $stable(tx_level));
  // R4
  tx_clear_spares_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_fifo_clr && !rx_fifo_clr && fifo_en && !rx_push && !rx_pop) |=> $stable(rx_level));
endmodule

// File: tb/fcr_unit_bench.sv
`timescale 1ns/1ps
module fcr_unit_bench;
  logic       clk = 1'b0;
  logic       rst, wr_en, rx_push, rx_pop, tx_push, tx_pop;
  logic [7:0] wr_data;
  logic       fifo_en, dma_mode, rx_fifo_clr, tx_fifo_clr, rx_irq;
  logic [1:0] rx_trig_sel;
  logic [4:0] rx_level, tx_level;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fcr_unit u_fcr_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rx_push(rx_push), .rx_pop(rx_pop), .tx_push(tx_push), .tx_pop(tx_pop),
    .fifo_en(fifo_en), .dma_mode(dma_mode), .rx_trig_sel(rx_trig_sel),
    .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr),
    .rx_level(rx_level), .tx_level(tx_level), .rx_irq(rx_irq)
  );

  // {byte, en, dma, trig[1:0], rxclr, txclr}
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {8'hC8, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0},  // R2 bit0 clear: rest ignored
    {8'h09, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0},  // R5 dma
    {8'h41, 1'b1, 1'b0, 2'b01, 1'b0, 1'b0},  // R6
    {8'h83, 1'b1, 1'b0, 2'b10, 1'b1, 1'b0},  // R3
    {8'hC5, 1'b1, 1'b0, 2'b11, 1'b0, 1'b1},  // R4
    {8'h39, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0},  // R5 bits 5:4 inert
    {8'hFE, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0},  // R2
    {8'hFF, 1'b1, 1'b1, 2'b11, 1'b1, 1'b1},  // R3 R4
    {8'h01, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0}   // R6
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_rx(input int n);
    rx_push = 1'b1; tick(n); rx_push = 1'b0;
  endtask

  task automatic pop_rx(input int n);
    rx_pop = 1'b1; tick(n); rx_pop = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0;
    rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 en", fifo_en, 0);  chk("R1 dma", dma_mode, 0);
    chk("R1 trig", rx_trig_sel, 0); chk("R1 rxlvl", rx_level, 0);
    chk("R1 irq", rx_irq, 0);  chk("R1 clr", rx_fifo_clr | tx_fifo_clr, 0);

    for (int i = 0; i < NV; i++) begin
      write(VEC[i][13:6]);
      chk("R2 en", fifo_en, VEC[i][5]);
      chk("R5 dma", dma_mode, VEC[i][4]);
      chk("R6 trig", rx_trig_sel, VEC[i][3:2]);
      chk("R3 rxclr", rx_fifo_clr, VEC[i][1]);
      chk("R4 txclr", tx_fifo_clr, VEC[i][0]);
      tick(1);
      chk("R3 rxclr drop", rx_fifo_clr, 0);
      chk("R4 txclr drop", tx_fifo_clr, 0);
    end

    // trigger 1
    push_rx(1); chk("R7 push", rx_level, 1);
    tick(1); chk("R8 trig1 hit", rx_irq, 1);
    pop_rx(1); chk("R7 pop", rx_level, 0);
    tick(1); chk("R8 below drops", rx_irq, 0);
    pop_rx(1); chk("R7 pop empty", rx_level, 0);

    // trigger 4
    write(8'h41);
    push_rx(3); tick(1); chk("R8 trig4 at3", rx_irq, 0);
    push_rx(1); tick(1); chk("R8 trig4 at4", rx_irq, 1);
    // trigger 8
    write(8'h81); tick(1); chk("R6 trig8 at4", rx_irq, 0);
    push_rx(4); tick(1); chk("R8 trig8 at8", rx_irq, 1);
    pop_rx(1); tick(1); chk("R8 trig8 at7", rx_irq, 0);
    // trigger 14 and saturation
    write(8'hC1);
    push_rx(6); tick(1); chk("R8 trig14 at13", rx_irq, 0);
    push_rx(6); chk("R7 saturate", rx_level, 16);
    tick(1); chk("R8 trig14 full", rx_irq, 1);
    rx_push = 1; rx_pop = 1; tick(1); rx_push = 0; rx_pop = 0;
    chk("R7 both at full", rx_level, 16);

    // selective clears
    tx_push = 1; tick(5); tx_push = 0;
    chk("R7 tx count", tx_level, 5);
    write(8'hC3); tick(1);
    chk("R3 rx cleared", rx_level, 0); chk("R3 tx kept", tx_level, 5);
    push_rx(2);
    write(8'hC5); tick(1);
    chk("R4 tx cleared", tx_level, 0); chk("R4 rx kept", rx_level, 2);

    // push during clear pulse
    write(8'h03);
    rx_push = 1; tick(1); rx_push = 0;
    chk("R10 push discarded", rx_level, 0);
    rx_push = 1; rx_pop = 1; tick(1); rx_push = 0; rx_pop = 0;
    chk("R7 both at empty", rx_level, 1);
    tick(1); chk("R8 trig1 again", rx_irq, 1);

    // disable
    write(8'h00); tick(1);
    chk("R9 level held 0", rx_level, 0); chk("R9 irq low", rx_irq, 0);
    push_rx(2); tx_push = 1; tick(1); tx_push = 0;
    chk("R9 rx push ignored", rx_level, 0); chk("R9 tx push ignored", tx_level, 0);
    chk("R9 irq still low", rx_irq, 0);

    // reset from a busy state
    write(8'h49); push_rx(2);
    rst = 1'b1; tick(2); rst = 1'b0; tick(1);
    chk("R1 en", fifo_en, 0); chk("R1 dma", dma_mode, 0);
    chk("R1 trig", rx_trig_sel, 0); chk("R1 rxlvl", rx_level, 0);
    chk("R1 irq", rx_irq, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule